// File: doc/BRIEF.md
# Free-Running Watchdog with Edge-Gated System Reset

This block is a watchdog down-counter that cannot be halted once out of reset. The host programs it through a small write port that reaches four internal locations: a reload value, a time-base selector, an output gate and an event status. Each time the host writes the reload value, the counter is loaded with it and the tick prescaler starts again from zero. Each unit tick then decrements the counter. A unit is one second or one minute, depending on the selector. When the count runs out, the counter reloads itself from the stored value and keeps running. At the same moment it raises a sticky event flag, which the host clears by writing a one.

A one-cycle system reset pulse is issued only at the moment the event flag goes from clear to set, and only if the output gate was already open before that edge. If the host opens the gate after the flag is already set, no reset follows. If the counter expires again while the flag is still set, no reset follows either. To turn the reset off, the host closes the gate. The counter itself keeps counting. Clock-per-second and second-per-minute counts are parameters, so a bench can shrink the time base.

Top module: `gated_wdog`

## Requirements
- R1: After reset, the event flag, output gate and reset pulse are 0, the time base is seconds (1), and the reload value and count are both RST_PRESET (default 60).
- R2: The write port decodes wr_addr as 0 = reload value (8 bits), 1 = time base (bit 0), 2 = output gate (bit 1), 3 = event status (bit 0). A write takes effect at the clock edge where wr_en is high.
- R3: A write to address 0 loads the count with wr_data at that edge and restarts the prescaler. In seconds mode with a reload of N (1..255), the expiry edge is the one exactly N*CLK_PER_SEC edges after the write edge.
- R4: With the time-base bit at 0 (minutes), the expiry edge comes N*CLK_PER_SEC*SEC_PER_MIN edges after the write edge.
- R5: At the expiry edge the count reloads to the stored reload value and the countdown goes on, so without further writes the next expiry follows one full period later.
- R6: Expiry sets the event flag. The flag stays set until a write to address 3 with bit 0 at 1 clears it. A write to address 3 with bit 0 at 0 leaves the flag unchanged. If a clear and an expiry fall on the same edge, the flag stays set.
- R7: The reset pulse is high for exactly one cycle, in the cycle the event flag first reads 1, and only if the output gate was 1 before that expiry edge.
- R8: Opening the output gate while the event flag is already set produces no reset pulse.
- R9: An expiry while the event flag is still set produces no reset pulse.
- R10: Only bit 1 of the output-gate write and bit 0 of the time-base write are stored. All other bits of those writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 reload, 1 time base, 2 output gate, 3 event status) |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current countdown value |
| tbase_sec_o | output | 1 | Time base: 1 = seconds, 0 = minutes |
| gate_o | output | 1 | Output gate state |
| event_o | output | 1 | Sticky expiry event flag |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The bench times each expiry to the exact edge in both time bases. A prescaler that is not restarted by a reload write, or that is off by one, moves the flag a cycle early or late. It checks that the counter reloads at expiry, since a counter that stalls at zero would never expire again. The gating cases cover a gate opened after the flag is already set and a repeated expiry while the flag is still set. A design that compared the gate level with the flag level, instead of sampling the rising edge, would fire a reset in both cases. Write-one-to-clear is checked with a write of zero, which must leave the flag set. Writes with stray bits to the gate and time-base registers are checked the same way.

// File: rtl/gated_wdog_pkg.sv
package gated_wdog_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_TBASE  = 2'd1,
    SEL_GATE   = 2'd2,
    SEL_EVENT  = 2'd3
  } wd_sel_e;

  localparam int unsigned GATE_BIT  = 1;
  localparam int unsigned TBASE_BIT = 0;
  localparam int unsigned EVENT_BIT = 0;
endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int unsigned CLK_PER_SEC = 100_000_000,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic arst_n,
  input  logic restart,
  input  logic use_sec,
  output logic unit_tick
);
  localparam int unsigned CW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam int unsigned MW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [CW-1:0] CLK_LAST = CW'(CLK_PER_SEC - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(SEC_PER_MIN - 1);

  logic [CW-1:0] clk_q, clk_d;
  logic [MW-1:0] sec_q, sec_d;
  logic          sec_tick, min_tick;

  assign sec_tick  = (clk_q == CLK_LAST);
  assign min_tick  = sec_tick && (sec_q == MIN_LAST);
  assign unit_tick = use_sec ? sec_tick : min_tick;

  always_comb begin
    clk_d = clk_q;
    sec_d = sec_q;
    if (restart) begin
      clk_d = '0;
      sec_d = '0;
    end else if (sec_tick) begin
      clk_d = '0;
      sec_d = (sec_q == MIN_LAST) ? '0 : sec_q + 1'b1;
    end else begin
      clk_d = clk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      clk_q <= '0;
      sec_q <= '0;
    end else begin
      clk_q <= clk_d;
      sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/wd_downcount.sv
module wd_downcount #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_PRESET = 60
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = tick && !load && (cnt_q <= CNT_W'(1));
  assign count  = cnt_q;

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    if (load) begin
      reload_d = load_val;
      cnt_d    = load_val;
    end else if (expire) begin
      cnt_d = reload_q;
    end else if (tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      reload_q <= CNT_W'(RST_PRESET);
      cnt_q    <= CNT_W'(RST_PRESET);
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/wd_event_gate.sv
module wd_event_gate (
  input  logic clk,
  input  logic arst_n,
  input  logic expire,
  input  logic clr,
  input  logic gate,
  output logic event_flag,
  output logic rst_pulse
);
  logic evt_q, evt_d;
  logic pls_q, pls_d;
  logic rise;

  assign rise = expire && !evt_q;

  always_comb begin
    evt_d = evt_q;
    if (expire)   evt_d = 1'b1;
    else if (clr) evt_d = 1'b0;
    pls_d = rise && gate;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      evt_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      pls_q <= pls_d;
    end
  end

  assign event_flag = evt_q;
  assign rst_pulse  = pls_q;
endmodule

// File: rtl/gated_wdog.sv
module gated_wdog
  import gated_wdog_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 100_000_000,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned RST_PRESET  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             tbase_sec_o,
  output logic             gate_o,
  output logic             event_o,
  output logic             sys_rst_o
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic wr_reload, wr_tbase, wr_gate, wr_event;
  assign wr_reload = wr_en && (wr_addr == SEL_RELOAD);
  assign wr_tbase  = wr_en && (wr_addr == SEL_TBASE);
  assign wr_gate   = wr_en && (wr_addr == SEL_GATE);
  assign wr_event  = wr_en && (wr_addr == SEL_EVENT);

  logic tbase_q, tbase_d, gate_q, gate_d;

  always_comb begin
    tbase_d = wr_tbase ? wr_data[TBASE_BIT] : tbase_q;
    gate_d  = wr_gate  ? wr_data[GATE_BIT]  : gate_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tbase_q <= 1'b1;
      gate_q  <= 1'b0;
    end else begin
      tbase_q <= tbase_d;
      gate_q  <= gate_d;
    end
  end

  logic unit_tick, expire;

  wd_tick_gen #(
    .CLK_PER_SEC (CLK_PER_SEC),
    .SEC_PER_MIN (SEC_PER_MIN)
  ) u_tick (
    .clk       (clk),
    .arst_n    (srst_n),
    .restart   (wr_reload),
    .use_sec   (tbase_q),
    .unit_tick (unit_tick)
  );

  wd_downcount #(
    .CNT_W      (CNT_W),
    .RST_PRESET (RST_PRESET)
  ) u_cnt (
    .clk      (clk),
    .arst_n   (srst_n),
    .load     (wr_reload),
    .load_val (CNT_W'(wr_data)),
    .tick     (unit_tick),
    .count    (count_o),
    .expire   (expire)
  );

  wd_event_gate u_evt (
    .clk        (clk),
    .arst_n     (srst_n),
    .expire     (expire),
    .clr        (wr_event && wr_data[EVENT_BIT]),
    .gate       (gate_q),
    .event_flag (event_o),
    .rst_pulse  (sys_rst_o)
  );

  assign tbase_sec_o = tbase_q;
  assign gate_o      = gate_q;
endmodule

// File: rtl/gated_wdog_chk.sv
module gated_wdog_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic             gate_o,
  input logic             event_o,
  input logic             sys_rst_o
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst_o |=> !sys_rst_o);

  // R7
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst_o |-> (event_o && !$past(event_o)));

  // R8
  pulse_needs_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst_o |-> $past(gate_o));

  // R6
  event_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (event_o && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> event_o);

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && wr_addr == 2'd0) |=> (count_o == CNT_W'($past(wr_data))));
endmodule

bind gated_wdog gated_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .arst_n    (srst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .count_o   (count_o),
  .gate_o    (gate_o),
  .event_o   (event_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/sim_gated_wdog.sv
module sim_gated_wdog;
  localparam int CPS = 4;
  localparam int SPM = 3;

  logic       clk, rst_n, wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] count_o;
  logic       tbase_sec_o, gate_o, event_o, sys_rst_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit wd_fired = 0;

  gated_wdog #(.CLK_PER_SEC(CPS), .SEC_PER_MIN(SPM)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .tbase_sec_o(tbase_sec_o),
    .gate_o(gate_o), .event_o(event_o), .sys_rst_o(sys_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (sys_rst_o) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // {tbase_sec, reload, gate}
  localparam logic [9:0] VEC [5] = '{
    {1'b1, 8'd1, 1'b1},
    {1'b1, 8'd3, 1'b0},
    {1'b0, 8'd1, 1'b1},
    {1'b1, 8'd5, 1'b1},
    {1'b0, 8'd2, 1'b0}
  };

  initial begin
    #150000;
    wd_fired = 1;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 event", event_o, 0);
    chk("R1 gate", gate_o, 0);
    chk("R1 pulse", sys_rst_o, 0);
    chk("R1 tbase", tbase_sec_o, 1);
    chk("R1 count", count_o, 60);

    // R3 R4 R5 R7 table walk
    for (int i = 0; i < 5; i++) begin
      automatic logic tb = VEC[i][9];
      automatic int   n  = VEC[i][8:1];
      automatic logic g  = VEC[i][0];
      automatic int   per = n * CPS * (tb ? 1 : SPM);
      wr(2'd0, 8'd255);
      wr(2'd1, {7'd0, tb});
      wr(2'd2, {6'd0, g, 1'b0});
      wr(2'd3, 8'h01);
      pulses = 0;
      wr(2'd0, n[7:0]);
      repeat (per - 1) @(negedge clk);
      chk("R3/R4 no early event", event_o, 0);
      @(negedge clk);
      chk("R3/R4 event on time", event_o, 1);
      chk("R7 pulse follows gate", sys_rst_o, g);
      chk("R5 reloaded count", count_o, n);
      @(negedge clk);
      chk("R7 single cycle", sys_rst_o, 0);
      repeat (per - 2) @(negedge clk);
      chk("R9 no pulse on second expiry", pulses, g ? 1 : 0);
      chk("R5 counter kept running", count_o, 1);
    end

    // R8 late gate
    wr(2'd0, 8'd255);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);
    pulses = 0;
    wr(2'd0, 8'd1);
    repeat (CPS) @(negedge clk);
    chk("R8 event set", event_o, 1);
    wr(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    chk("R8 late gate no pulse", pulses, 0);
    // R9 repeated expiries with flag still set
    repeat (3 * CPS) @(negedge clk);
    chk("R9 no pulse while flag set", pulses, 0);
    chk("R9 flag still set", event_o, 1);

    // R6 write-one-to-clear
    wr(2'd0, 8'd200);
    wr(2'd3, 8'hFE);
    chk("R6 zero write keeps flag", event_o, 1);
    wr(2'd3, 8'h01);
    chk("R6 one clears flag", event_o, 0);

    // R10 stray bits ignored
    wr(2'd2, 8'hFD);
    chk("R10 gate ignores other bits", gate_o, 0);
    wr(2'd2, 8'h02);
    chk("R10 gate bit1 sets", gate_o, 1);
    wr(2'd1, 8'hFE);
    chk("R10 tbase ignores other bits", tbase_sec_o, 0);
    wr(2'd1, 8'h01);
    chk("R2 tbase bit0 sets", tbase_sec_o, 1);

    // R3 reload write restarts countdown
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd3);
    repeat (8) @(negedge clk);
    wr(2'd0, 8'd3);
    repeat (3 * CPS - 1) @(negedge clk);
    chk("R3 restart delays expiry", event_o, 0);
    @(negedge clk);
    chk("R3 expiry after restart", event_o, 1);

    if (!wd_fired) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule